// File: doc/BRIEF.md
# 64-bit Integer Execute Stage

This block is the integer execute stage of a 64-bit load/store core that keeps no condition codes. Each operation takes a first operand, a second operand that is either a register value or a short literal, an operation code and a size select. The result goes into one output register. Compares return 0 or 1 as an ordinary register value. A conditional move tells writeback whether to commit with a write-enable bit, so the destination keeps its old value when the test fails. Signed overflow is reported only by the trapping add and subtract.

Both edges of the stage are valid/ready streams. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result appears in the output register one cycle later. The stage accepts new work whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the stage holds the result, write-enable and overflow bit unchanged and does not accept new work. Operation codes 28 to 31 are unused: they return a zero result with write-enable low and overflow low.

Top module: `int_exec_unit`

## Requirements
- R1: After reset `out_valid` is 0. A result is presented in the cycle after its operation is accepted. `in_ready` equals `!out_valid || out_ready`. Outputs stay unchanged while `out_valid` is high and `out_ready` is low. Results leave in the order their operations were accepted.
- R2: When `in_use_lit` is 1, the second operand is `in_lit` zero-extended to 64 bits and `in_b` is not used.
- R3: Op 0 returns a+b and op 1 returns a-b. With `in_size_lw` = 1, only the low 32 bits of both operands are used, and the 32-bit result is sign-extended to 64 bits.
- R4: Ops 4 and 5 return a+(b<<2) and a+(b<<3). Ops 6 and 7 return a-(b<<2) and a-(b<<3). The longword rule of R3 applies after the shift.
- R5: Op 2 (add) and op 3 (subtract) give the same result as ops 0 and 1. They raise `out_ovf` when the true signed result does not fit the selected width (32 or 64 bits). Every other op leaves `out_ovf` low.
- R6: The compares return 1 when the condition holds and 0 otherwise: op 8 a==b, op 9 a<b signed, op 10 a<=b signed, op 11 a<b unsigned, op 12 a<=b unsigned.
- R7: The bitwise ops are op 13 AND, 14 NAND, 15 OR, 16 NOR, 17 XOR and 18 XNOR.
- R8: The shifts are op 19 logical left, 20 logical right and 21 arithmetic right. They shift a by the low 6 bits of the second operand.
- R9: Ops 22 to 27 are conditional moves. They test a as a signed value against zero for eq, ne, lt, le, ge and gt, in that order. The result is the second operand and `out_wen` is the outcome of the test. Ops 0 to 21 always give `out_wen` = 1.
- R10: `in_size_lw` has no effect on ops 8 to 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can accept an operation |
| in_op | input | 5 | Operation code (R3 to R9) |
| in_size_lw | input | 1 | 1 selects the 32-bit form of the add/sub group |
| in_use_lit | input | 1 | 1 selects the literal as second operand |
| in_lit | input | 8 | Literal, zero-extended |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand register value |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result value |
| out_wen | output | 1 | Writeback should commit the result |
| out_ovf | output | 1 | Signed overflow on a trapping add/sub |

## Verification
Any wrong internal value is visible at the ports on the very next transfer: the result register is the only state, so a bad operand path, a bad scale or a bad overflow test shows up in the first result of an affected operation. The risky points are the 32-bit sign extension at bit 31, overflow at both widths, shift amounts above 63, and the signed versus unsigned compares at values with the top bit set. Back-pressure errors appear as a result that changes while stalled, or as a missing or duplicated result in the in-order stream. These are seen within one cycle of the stall.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_ADDV   = 5'd2,
    OP_SUBV   = 5'd3,
    OP_S4ADD  = 5'd4,
    OP_S8ADD  = 5'd5,
    OP_S4SUB  = 5'd6,
    OP_S8SUB  = 5'd7,
    OP_CMPEQ  = 5'd8,
    OP_CMPLT  = 5'd9,
    OP_CMPLE  = 5'd10,
    OP_CMPULT = 5'd11,
    OP_CMPULE = 5'd12,
    OP_AND    = 5'd13,
    OP_NAND   = 5'd14,
    OP_OR     = 5'd15,
    OP_NOR    = 5'd16,
    OP_XOR    = 5'd17,
    OP_XNOR   = 5'd18,
    OP_SLL    = 5'd19,
    OP_SRL    = 5'd20,
    OP_SRA    = 5'd21,
    OP_MVEQ   = 5'd22,
    OP_MVNE   = 5'd23,
    OP_MVLT   = 5'd24,
    OP_MVLE   = 5'd25,
    OP_MVGE   = 5'd26,
    OP_MVGT   = 5'd27
  } op_e;

  localparam int OP_W = 5;

endpackage

// File: rtl/iexu_addsub.sv
module iexu_addsub
  import iexu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op,
  input  logic            size_lw,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output logic            ovf
);
  localparam int HALF = XLEN / 2;

  logic [1:0]      scale;
  logic            negate;
  logic            trapping;
  logic [XLEN-1:0] b_scaled;
  logic [XLEN-1:0] b_term;
  logic [XLEN-1:0] raw;
  logic            sa, sb, sr;

  always_comb begin
    scale    = 2'd0;
    negate   = 1'b0;
    trapping = 1'b0;
    unique case (op)
      OP_SUB:   negate = 1'b1;
      OP_ADDV:  trapping = 1'b1;
      OP_SUBV:  begin negate = 1'b1; trapping = 1'b1; end
      OP_S4ADD: scale = 2'd2;
      OP_S8ADD: scale = 2'd3;
      OP_S4SUB: begin scale = 2'd2; negate = 1'b1; end
      OP_S8SUB: begin scale = 2'd3; negate = 1'b1; end
      default:  ;
    endcase
  end

  assign b_scaled = b << scale;
  assign b_term   = negate ? ~b_scaled : b_scaled;
  assign raw      = a + b_term + {{(XLEN-1){1'b0}}, negate};

  // sign bits at the selected width
  assign sa = size_lw ? a[HALF-1]      : a[XLEN-1];
  assign sb = size_lw ? b_term[HALF-1] : b_term[XLEN-1];
  assign sr = size_lw ? raw[HALF-1]    : raw[XLEN-1];

  assign sum = size_lw ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
  assign ovf = trapping && (sa == sb) && (sr != sa);

endmodule

// File: rtl/iexu_bitshift.sv
module iexu_bitshift
  import iexu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LANE = 8
) (
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int NLANE = XLEN / LANE;
  localparam int SHW   = $clog2(XLEN);

  logic [XLEN-1:0] bitwise;
  logic [SHW-1:0]  amount;
  logic [XLEN-1:0] sh_left, sh_right, sh_arith;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE-1:0] la, lb, lo;
    assign la = a[g*LANE +: LANE];
    assign lb = b[g*LANE +: LANE];
    always_comb begin
      unique case (op)
        OP_AND:  lo = la & lb;
        OP_NAND: lo = ~(la & lb);
        OP_OR:   lo = la | lb;
        OP_NOR:  lo = ~(la | lb);
        OP_XOR:  lo = la ^ lb;
        OP_XNOR: lo = ~(la ^ lb);
        default: lo = '0;
      endcase
    end
    assign bitwise[g*LANE +: LANE] = lo;
  end

  assign amount   = b[SHW-1:0];
  assign sh_left  = a << amount;
  assign sh_right = a >> amount;
  assign sh_arith = $signed(a) >>> amount;

  always_comb begin
    unique case (op)
      OP_SLL:  y = sh_left;
      OP_SRL:  y = sh_right;
      OP_SRA:  y = sh_arith;
      default: y = bitwise;
    endcase
  end

endmodule

// File: rtl/iexu_test.sv
module iexu_test
  import iexu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            cmp_true,
  output logic            move_take
);
  logic zero, neg;
  logic [5:0] zcond;

  assign zero = (a == '0);
  assign neg  = a[XLEN-1];

  // zero tests in the order eq, ne, lt, le, ge, gt
  assign zcond = {!neg && !zero, !neg, neg || zero, neg, !zero, zero};

  always_comb begin
    unique case (op)
      OP_CMPEQ:  cmp_true = (a == b);
      OP_CMPLT:  cmp_true = ($signed(a) <  $signed(b));
      OP_CMPLE:  cmp_true = ($signed(a) <= $signed(b));
      OP_CMPULT: cmp_true = (a <  b);
      OP_CMPULE: cmp_true = (a <= b);
      default:   cmp_true = 1'b0;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_MVEQ: move_take = zcond[0];
      OP_MVNE: move_take = zcond[1];
      OP_MVLT: move_take = zcond[2];
      OP_MVLE: move_take = zcond[3];
      OP_MVGE: move_take = zcond[4];
      OP_MVGT: move_take = zcond[5];
      default: move_take = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LIT_W = 8,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_size_lw,
  input  logic             in_use_lit,
  input  logic [LIT_W-1:0] in_lit,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic             out_wen,
  output logic             out_ovf
);
  localparam int HALF = XLEN / 2;

  op_e             op;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] as_sum;
  logic            as_ovf;
  logic [XLEN-1:0] bs_y;
  logic            cmp_true;
  logic            move_take;
  logic [XLEN-1:0] nx_result;
  logic            nx_wen;
  logic            nx_ovf;
  logic            accept;

  assign op     = op_e'(in_op);
  assign b_eff  = in_use_lit ? {{(XLEN-LIT_W){1'b0}}, in_lit} : in_b;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  iexu_addsub #(.XLEN(XLEN)) i_addsub (
    .op(op), .size_lw(in_size_lw), .a(in_a), .b(b_eff),
    .sum(as_sum), .ovf(as_ovf)
  );

  iexu_bitshift #(.XLEN(XLEN), .LANE(LANE)) i_bitshift (
    .op(op), .a(in_a), .b(b_eff), .y(bs_y)
  );

  iexu_test #(.XLEN(XLEN)) i_test (
    .op(op), .a(in_a), .b(b_eff),
    .cmp_true(cmp_true), .move_take(move_take)
  );

  always_comb begin
    nx_result = '0;
    nx_wen    = 1'b1;
    nx_ovf    = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDV, OP_SUBV,
      OP_S4ADD, OP_S8ADD, OP_S4SUB, OP_S8SUB: begin
        nx_result = as_sum;
        nx_ovf    = as_ovf;
      end
      OP_CMPEQ, OP_CMPLT, OP_CMPLE, OP_CMPULT, OP_CMPULE:
        nx_result = {{(XLEN-1){1'b0}}, cmp_true};
      OP_AND, OP_NAND, OP_OR, OP_NOR, OP_XOR, OP_XNOR,
      OP_SLL, OP_SRL, OP_SRA:
        nx_result = bs_y;
      OP_MVEQ, OP_MVNE, OP_MVLT, OP_MVLE, OP_MVGE, OP_MVGT: begin
        nx_result = b_eff;
        nx_wen    = move_take;
      end
      default: nx_wen = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wen    <= 1'b0;
      out_ovf    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nx_result;
        out_wen    <= nx_wen;
        out_ovf    <= nx_ovf;
      end
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_wen) && $stable(out_ovf)));

  // R1
  present_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R3
  lw_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_size_lw && (in_op <= 5'd7))
      |=> (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op != OP_ADDV) && (op != OP_SUBV)) |=> !out_ovf);

  // R6
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op >= 5'd8) && (in_op <= 5'd12))
      |=> (out_result[XLEN-1:1] == '0));

  // R9
  wen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op <= 5'd21)) |=> out_wen);

endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

  typedef struct {
    logic [63:0] res;
    logic        wen;
    logic        ovf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic        in_size_lw = 1'b0;
  logic        in_use_lit = 1'b0;
  logic [7:0]  in_lit = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_wen;
  logic        out_ovf;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  bit   accepted;
  bit   last_acc = 0;
  bit   prev_stall = 0;
  logic [63:0] prev_res;
  logic prev_wen, prev_ovf;
  bit   force_ready = 0;

  always #2 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size_lw(in_size_lw), .in_use_lit(in_use_lit),
    .in_lit(in_lit), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wen(out_wen),
    .out_ovf(out_ovf)
  );

  function automatic logic [65:0] model(int op, bit lw, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    logic w = 1'b1, v = 1'b0;
    logic [64:0] wide;
    logic [32:0] narrow;
    logic [63:0] bs;
    int sc;
    if (op <= 7) begin
      sc = (op == 4 || op == 6) ? 2 : (op == 5 || op == 7) ? 3 : 0;
      bs = b << sc;
      if (op == 1 || op == 3 || op == 6 || op == 7) begin
        r = a - bs;
        wide = $signed({a[63], a}) - $signed({bs[63], bs});
        narrow = $signed({a[31], a[31:0]}) - $signed({bs[31], bs[31:0]});
      end else begin
        r = a + bs;
        wide = $signed({a[63], a}) + $signed({bs[63], bs});
        narrow = $signed({a[31], a[31:0]}) + $signed({bs[31], bs[31:0]});
      end
      if (lw) r = {{32{r[31]}}, r[31:0]};
      if (op == 2 || op == 3) v = lw ? (narrow[32] != narrow[31]) : (wide[64] != wide[63]);
    end else case (op)
      8:  r = {63'd0, a == b};
      9:  r = {63'd0, $signed(a) <  $signed(b)};
      10: r = {63'd0, $signed(a) <= $signed(b)};
      11: r = {63'd0, a <  b};
      12: r = {63'd0, a <= b};
      13: r = a & b;
      14: r = ~(a & b);
      15: r = a | b;
      16: r = ~(a | b);
      17: r = a ^ b;
      18: r = ~(a ^ b);
      19: r = a << b[5:0];
      20: r = a >> b[5:0];
      21: r = $signed(a) >>> b[5:0];
      default: begin
        r = b;
        case (op)
          22: w = (a == 0);
          23: w = (a != 0);
          24: w = $signed(a) < 0;
          25: w = $signed(a) <= 0;
          26: w = $signed(a) >= 0;
          default: w = $signed(a) > 0;
        endcase
      end
    endcase
    return {v, w, r};
  endfunction

  function automatic string req_of(int op, bit lw, bit lit);
    string s;
    if (op <= 1) s = "R3";
    else if (op <= 3) s = "R5";
    else if (op <= 7) s = "R4";
    else if (op <= 12) s = "R6";
    else if (op <= 18) s = "R7";
    else if (op <= 21) s = "R8";
    else s = "R9";
    if (lit) s = {s, "/R2"};
    if (lw && op >= 8) s = {s, "/R10"};
    return s;
  endfunction

  task automatic check(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic cycle();
    exp_t e;
    logic [63:0] b_used;
    logic [65:0] m;
    out_ready = force_ready ? 1'b1 : ($urandom_range(0, 3) != 0);
    #1;
    if (last_acc)
      check(out_valid === 1'b1, "R1", $sformatf("out_valid=%b expected 1 after accept", out_valid));
    if (prev_stall)
      check(out_result === prev_res && out_wen === prev_wen && out_ovf === prev_ovf, "R1",
            $sformatf("stalled result %h/%b/%b expected %h/%b/%b", out_result, out_wen, out_ovf,
                      prev_res, prev_wen, prev_ovf));
    check(in_ready === (!out_valid || out_ready), "R1",
          $sformatf("in_ready=%b expected %b", in_ready, !out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (q.size() == 0) check(1'b0, "R1", "result with none expected, expected none");
      else begin
        e = q.pop_front();
        check(out_result === e.res && out_wen === e.wen && out_ovf === e.ovf, e.tag,
              $sformatf("result %h wen %b ovf %b, expected %h wen %b ovf %b",
                        out_result, out_wen, out_ovf, e.res, e.wen, e.ovf));
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_res = out_result; prev_wen = out_wen; prev_ovf = out_ovf;
    accepted = in_valid && in_ready;
    last_acc = accepted;
    if (accepted) begin
      b_used = in_use_lit ? {56'd0, in_lit} : in_b;
      m = model(int'(in_op), in_size_lw, in_a, b_used);
      e.res = m[63:0]; e.wen = m[64]; e.ovf = m[65];
      e.tag = req_of(int'(in_op), in_size_lw, in_use_lit);
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic send(int op, bit lw, bit lit_en, logic [7:0] lit, logic [63:0] a, logic [63:0] b);
    in_valid = 1'b1; in_op = op[4:0]; in_size_lw = lw; in_use_lit = lit_en;
    in_lit = lit; in_a = a; in_b = b;
    accepted = 0;
    while (!accepted) cycle();
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 9))
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h7fff_ffff_ffff_ffff;
      4: return 64'h8000_0000_0000_0000;
      5: return 64'h0000_0000_7fff_ffff;
      6: return 64'hffff_ffff_8000_0000;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(out_valid === 1'b0, "R1", $sformatf("out_valid=%b in reset, expected 0", out_valid));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1",
          $sformatf("after reset valid=%b ready=%b, expected 0/1", out_valid, in_ready));
    @(negedge clk);

    // R3 longword add wraps at bit 31 and sign-extends
    send(0, 1, 0, 0, 64'hdead_beef_7fff_ffff, 64'h1234_5678_0000_0001);
    // R5 quadword trap on max+1, none on small sum
    send(2, 0, 0, 0, 64'h7fff_ffff_ffff_ffff, 64'd1);
    send(2, 0, 0, 0, 64'd5, 64'd7);
    // R5 longword subtract overflow, plain sub never traps
    send(3, 1, 0, 0, 64'h0000_0000_8000_0000, 64'd1);
    send(1, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd1);
    // R4 scaled add on longword, scaled sub does not trap
    send(5, 1, 0, 0, 64'd3, 64'h0000_0000_1000_0000);
    send(7, 0, 0, 0, 64'h8000_0000_0000_0000, 64'h0100_0000_0000_0000);
    // R2 literal zero-extends, in_b ignored
    send(0, 0, 1, 8'hff, 64'd1, '1);
    // R6 signed vs unsigned at -1 and 1
    send(11, 0, 0, 0, '1, 64'd1);
    send(9, 0, 0, 0, '1, 64'd1);
    send(12, 0, 0, 0, 64'd4, 64'd4);
    // R8 shift amount uses only low 6 bits (0x41 -> 1)
    send(21, 0, 1, 8'h41, 64'h8000_0000_0000_0010, 64'd0);
    send(19, 0, 0, 0, 64'd1, 64'd63);
    // R9 failed move clears write-enable, taken move passes b
    send(22, 0, 0, 0, 64'd9, 64'h55);
    send(27, 0, 0, 0, 64'd9, 64'h66);
    // R10 longword select does not touch bitwise result
    send(18, 1, 0, 0, 64'hf0f0_0000_1234_5678, 64'h0ff0_0000_0000_0000);
    // R7 each bitwise op
    for (int k = 13; k <= 18; k++) send(k, 0, 0, 0, 64'hff00_aa55_0f0f_1234, 64'h0ff0_5a5a_ffff_0000);

    for (int n = 0; n < 1500; n++)
      send($urandom_range(0, 27), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
           8'($urandom()), pick(), pick());

    force_ready = 1;
    for (int n = 0; n < 8 && q.size() != 0; n++) cycle();
    check(q.size() == 0, "R1", $sformatf("%0d results missing, expected 0", q.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule